// File: doc/BRIEF.md
# Variable-Length Instruction Stream Decoder

This block sits in front of the control path of a reconfigurable matrix-multiply accelerator. It receives a packed bit stream of instructions whose lengths differ, finds where each instruction ends, and hands each one onward as a decoded record. The record carries a 3-bit opcode, up to six zero-extended field slots and an error flag. The first three bits of every instruction are the opcode. The opcode, together with the elaboration-time array width, array height and buffer row counts, fixes how long the instruction is and where its fields lie.

Bits enter MSB-first through a valid/ready port, with 1 to `IN_W` bits per beat. The valid bits sit at the top of `in_data`. Bits that are left over stay in a window register, so an instruction may span any number of beats and a beat may hold the tail of one instruction and the head of the next. Records leave through a second valid/ready port. Back-pressure rules: a record with `out_valid` high holds steady until `out_ready` is seen high at a clock edge. While a record is stalled, `in_ready` is low and no input bit is taken. `in_ready` also drops when the window lacks room for a full beat. A beat is taken on any edge where `in_valid` and `in_ready` are both high.

Top module: `vlid_stream_decoder`

## Requirements
- R1: Instruction length is 3 bits of opcode plus the widths of its fields. Field widths use A = clog2(ARR_W), H = clog2(ARR_H), Rw = clog2(STA_ROWS), Rt = clog2(STA_ROWS*ARR_W), Ri = clog2(STR_ROWS) and Ro = clog2(OUT_ROWS), each at least 1. With the defaults (4, 4, 16, 16, 8) the lengths are 16, 16, 14, 18, 33, 33, 11 and 29 bits for opcodes 0 to 7, and consecutive instructions are decoded back to back with no gap bits.
- R2: The layout opcodes 0 (weight), 1 (input) and 2 (output) each fill four slots: slot 0 is the 3-bit order, slot 1 is an A-bit inner factor, and slots 2 and 3 are two factors of Rw (opcode 0), Ri (opcode 1) or Ro (opcode 2) bits.
- R3: Opcode 7 (execute-mapping) fills six slots in this order: row-share group (A), replication period (A), base row (Rt), base column (Rt), row stride (Rt) and column stride (Rw).
- R4: Opcode 3 (execute-streaming) fills five slots: slot 0 is the 1-bit dataflow flag (1 = weight-stationary, 0 = input-stationary), slots 1 to 3 are base row, row stride and step count of Ri bits each, and slot 4 is the H-bit VN height minus one.
- R5: Opcodes 4 (store) and 5 (load) put the 1-bit target in slot 0 and the 29-bit off-chip address in slot 1. Opcode 6 (activation) puts its 8-bit reserved field in slot 0.
- R6: A layout instruction whose order field is 6 or 7 is delivered with `out_err` high. The decoder still consumes its full length, so the next instruction decodes correctly. `out_err` is low for every other record.
- R7: Fields are read MSB-first across beats. A beat carries `in_nbits` bits (1 to `IN_W`) taken from the top of `in_data`. The bits below them are ignored.
- R8: While `out_valid` is high and `out_ready` is low, the record is held unchanged and `in_ready` is low.
- R9: During reset `out_valid` is low. Once reset is released with nothing buffered, `in_ready` is high.
- R10: Slots that the opcode does not use, and the bits of any slot above its field width, read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Decoder can take a beat |
| in_data | input | IN_W | Beat bits, valid ones left-aligned |
| in_nbits | input | clog2(IN_W+1) | Number of valid bits in the beat |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_op | output | 3 | Opcode of the record |
| out_err | output | 1 | Order field out of range |
| out_fld | output | 6*FLD_W | Field slots, slot i at bits [i*FLD_W +: FLD_W] |

## Verification
The assertions check the handshake rules on every cycle: a stalled record stays frozen and blocks input, the error flag appears only on layout records with an order above five, and the unused slots of store, load and activation records stay zero. They also check the reset state and that the input beat never claims more than `IN_W` bits. Correct boundaries and field contents can only be shown by the bench's scenarios. The bench sweeps every opcode and every order value, with zero, all-ones and mixed field values. It uses beat sizes from 1 to `IN_W` bits, sets junk bits below the valid ones, and inserts idle input cycles and irregular output stalls, then compares each record against values it packs and computes itself.

// File: rtl/vlid_pkg.sv
package vlid_pkg;

  typedef enum logic [2:0] {
    OP_WLAY  = 3'd0,
    OP_ILAY  = 3'd1,
    OP_OLAY  = 3'd2,
    OP_XSTR  = 3'd3,
    OP_STORE = 3'd4,
    OP_LOAD  = 3'd5,
    OP_ACT   = 3'd6,
    OP_XMAP  = 3'd7
  } vlid_op_e;

  localparam int OP_W    = 3;
  localparam int ORD_W   = 3;
  localparam int ORD_MAX = 5;
  localparam int SEL_W   = 1;
  localparam int HBM_W   = 29;
  localparam int RSV_W   = 8;
  localparam int FLAG_W  = 1;
  localparam int NSLOT   = 6;

  // log2 ceiling that never yields a zero-width field
  function automatic int lg1(input int v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // longest instruction for a given array / buffer configuration
  function automatic int max_len(input int aw, input int ah, input int sta,
                                 input int str, input int ob);
    int lay, xmap, xstr, dma, act;
    lay  = OP_W + ORD_W + lg1(aw) + 2 * imax(lg1(sta), imax(lg1(str), lg1(ob)));
    xmap = OP_W + 2 * lg1(aw) + 3 * lg1(sta * aw) + lg1(sta);
    xstr = OP_W + FLAG_W + 3 * lg1(str) + lg1(ah);
    dma  = OP_W + SEL_W + HBM_W;
    act  = OP_W + RSV_W;
    return imax(imax(lay, xmap), imax(imax(xstr, dma), act));
  endfunction

endpackage

// File: rtl/vlid_bit_window.sv
module vlid_bit_window #(
  parameter int IN_W  = 16,
  parameter int BUF_W = 48,
  parameter int WIN_W = 33,
  localparam int CW   = $clog2(BUF_W + 1),
  localparam int NBW  = $clog2(IN_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [IN_W-1:0]  in_data,
  input  logic [NBW-1:0]   in_nbits,
  input  logic             pop,
  input  logic [CW-1:0]    pop_len,
  output logic             room,
  output logic [CW-1:0]    cnt,
  output logic [WIN_W-1:0] win
);

  logic [BUF_W-1:0] bits_q, shifted, ext, bits_d;
  logic [IN_W-1:0]  masked;
  logic [CW-1:0]    left, cnt_d;

  // invariant: bits below the first cnt positions are zero
  assign room = (cnt <= CW'(BUF_W - IN_W));
  assign win  = bits_q[BUF_W-1 -: WIN_W];

  always_comb begin
    left    = pop ? (cnt - pop_len) : cnt;
    shifted = pop ? (bits_q << pop_len) : bits_q;
    masked  = in_data & ~({IN_W{1'b1}} >> in_nbits);
    ext     = {masked, {(BUF_W - IN_W){1'b0}}} >> left;
    bits_d  = shifted | (take ? ext : '0);
    cnt_d   = left + (take ? CW'(in_nbits) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      cnt    <= '0;
    end else begin
      bits_q <= bits_d;
      cnt    <= cnt_d;
    end
  end

endmodule

// File: rtl/vlid_field_slicer.sv
module vlid_field_slicer
  import vlid_pkg::*;
#(
  parameter int ARR_W    = 4,
  parameter int ARR_H    = 4,
  parameter int STA_ROWS = 16,
  parameter int STR_ROWS = 16,
  parameter int OUT_ROWS = 8,
  parameter int WIN_W    = 33,
  parameter int FLD_W    = 29,
  parameter int LEN_W    = 6
) (
  input  logic [WIN_W-1:0]              win,
  output logic [OP_W-1:0]               op,
  output logic [LEN_W-1:0]              len,
  output logic [NSLOT-1:0][FLD_W-1:0]   fld,
  output logic                          err
);

  localparam int B_AW   = lg1(ARR_W);
  localparam int B_VN   = lg1(ARR_H);
  localparam int B_STA  = lg1(STA_ROWS);
  localparam int B_STAT = lg1(STA_ROWS * ARR_W);
  localparam int B_STR  = lg1(STR_ROWS);
  localparam int B_OUT  = lg1(OUT_ROWS);

  // width of slot i for opcode o; zero marks an unused slot
  function automatic int slot_w(input logic [OP_W-1:0] o, input int i);
    int r;
    r = 0;
    case (vlid_op_e'(o))
      OP_WLAY, OP_ILAY, OP_OLAY: begin
        if (i == 0)      r = ORD_W;
        else if (i == 1) r = B_AW;
        else if (i < 4)  r = (o == OP_WLAY) ? B_STA : (o == OP_ILAY) ? B_STR : B_OUT;
      end
      OP_XMAP: begin
        if (i < 2)       r = B_AW;
        else if (i < 5)  r = B_STAT;
        else             r = B_STA;
      end
      OP_XSTR: begin
        if (i == 0)      r = FLAG_W;
        else if (i < 4)  r = B_STR;
        else if (i == 4) r = B_VN;
      end
      OP_STORE, OP_LOAD: begin
        if (i == 0)      r = SEL_W;
        else if (i == 1) r = HBM_W;
      end
      OP_ACT: begin
        if (i == 0)      r = RSV_W;
      end
      default: r = 0;
    endcase
    return r;
  endfunction

  logic [WIN_W-1:0] sh;

  always_comb begin
    int off;
    int w;
    op  = win[WIN_W-1 -: OP_W];
    off = OP_W;
    sh  = '0;
    for (int i = 0; i < NSLOT; i++) begin
      w  = slot_w(op, i);
      sh = win << off;
      fld[i] = (w == 0) ? '0 : FLD_W'(sh >> (WIN_W - w));
      off = off + w;
    end
    len = LEN_W'(off);
    err = (op <= 3'(OP_OLAY)) && (fld[0][ORD_W-1:0] > 3'(ORD_MAX));
  end

endmodule

// File: rtl/vlid_stream_decoder.sv
module vlid_stream_decoder
  import vlid_pkg::*;
#(
  parameter int ARR_W    = 4,
  parameter int ARR_H    = 4,
  parameter int STA_ROWS = 16,
  parameter int STR_ROWS = 16,
  parameter int OUT_ROWS = 8,
  parameter int IN_W     = 16,
  parameter int FLD_W    = 29
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [IN_W-1:0]            in_data,
  input  logic [$clog2(IN_W+1)-1:0]  in_nbits,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [2:0]                 out_op,
  output logic                       out_err,
  output logic [6*FLD_W-1:0]         out_fld
);

  localparam int WIN_W = max_len(ARR_W, ARR_H, STA_ROWS, STR_ROWS, OUT_ROWS);
  localparam int BUF_W = WIN_W + IN_W - 1;
  localparam int CW    = $clog2(BUF_W + 1);
  localparam int LEN_W = $clog2(WIN_W + 1);

  logic                       room, take, pop, stall;
  logic [CW-1:0]              cnt;
  logic [WIN_W-1:0]           win;
  logic [OP_W-1:0]            dec_op;
  logic [LEN_W-1:0]           dec_len;
  logic [NSLOT-1:0][FLD_W-1:0] dec_fld;
  logic                       dec_err;

  assign stall    = out_valid && !out_ready;
  assign in_ready = room && !stall;
  assign take     = in_valid && in_ready;
  assign pop      = !stall && (cnt >= CW'(OP_W)) && (cnt >= CW'(dec_len));

  vlid_bit_window #(
    .IN_W (IN_W),
    .BUF_W(BUF_W),
    .WIN_W(WIN_W)
  ) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .in_data (in_data),
    .in_nbits(in_nbits),
    .pop     (pop),
    .pop_len (CW'(dec_len)),
    .room    (room),
    .cnt     (cnt),
    .win     (win)
  );

  vlid_field_slicer #(
    .ARR_W   (ARR_W),
    .ARR_H   (ARR_H),
    .STA_ROWS(STA_ROWS),
    .STR_ROWS(STR_ROWS),
    .OUT_ROWS(OUT_ROWS),
    .WIN_W   (WIN_W),
    .FLD_W   (FLD_W),
    .LEN_W   (LEN_W)
  ) u_slice (
    .win(win),
    .op (dec_op),
    .len(dec_len),
    .fld(dec_fld),
    .err(dec_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_op    <= '0;
      out_err   <= 1'b0;
      out_fld   <= '0;
    end else if (pop) begin
      out_valid <= 1'b1;
      out_op    <= dec_op;
      out_err   <= dec_err;
      out_fld   <= dec_fld;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/vlid_decoder_chk.sv
module vlid_decoder_chk #(
  parameter int IN_W  = 16,
  parameter int FLD_W = 29
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic [$clog2(IN_W+1)-1:0] in_nbits,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [2:0]                out_op,
  input logic                      out_err,
  input logic [6*FLD_W-1:0]        out_fld
);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r9_idle_in_reset: assert (!out_valid);
    end
  end

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_op) && $stable(out_fld) && $stable(out_err));

  a_r8_no_take_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r6_err_layout_only: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> (out_op <= 3'd2) && (out_fld[2:0] > 3'd5));

  a_r10_act_slots_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_op == 3'd6 |-> out_fld[6*FLD_W-1:8] == '0);

  a_r5_dma_slots_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_op == 3'd4 || out_op == 3'd5) |->
      out_fld[FLD_W-1:1] == '0 && out_fld[6*FLD_W-1:2*FLD_W] == '0);

  a_r7_beat_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_nbits <= ($clog2(IN_W+1))'(IN_W));

endmodule

bind vlid_stream_decoder vlid_decoder_chk #(
  .IN_W (IN_W),
  .FLD_W(FLD_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_nbits (in_nbits),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_op   (out_op),
  .out_err  (out_err),
  .out_fld  (out_fld)
);

// File: tb/vlid_stream_decoder_tb.sv
module vlid_stream_decoder_tb;

  localparam int CLK_P = 10;
  localparam int IN_W  = 16;
  localparam int NBW   = $clog2(IN_W + 1);
  localparam int FW    = 29;
  localparam int NS    = 6;
  localparam int TAW   = $clog2(4);
  localparam int TVN   = $clog2(4);
  localparam int TSTA  = $clog2(16);
  localparam int TSTAT = $clog2(64);
  localparam int TSTR  = $clog2(16);
  localparam int TOUT  = $clog2(8);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [IN_W-1:0] in_data = '0;
  logic [NBW-1:0] in_nbits = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [2:0] out_op;
  logic out_err;
  logic [NS*FW-1:0] out_fld;

  always #(CLK_P/2) clk = ~clk;

  vlid_stream_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_nbits(in_nbits), .out_valid(out_valid),
    .out_ready(out_ready), .out_op(out_op), .out_err(out_err), .out_fld(out_fld)
  );

  int checks = 0;
  int fails  = 0;
  bit bq[$];
  logic [2:0] eop[$];
  logic [NS*FW-1:0] efl[$];
  logic eerr[$];
  logic [NS*FW-1:0] emsk[$];
  int unsigned seed = 32'h1234_5678;
  int total_bits = 0;
  int taken_bits = 0;
  int n_instr = 0;
  int n_out = 0;

  // field widths per opcode and slot, from the requirement text
  function automatic int tw(input int op, input int i);
    case (op)
      0: return (i == 0) ? 3 : (i == 1) ? TAW : (i < 4) ? TSTA : 0;
      1: return (i == 0) ? 3 : (i == 1) ? TAW : (i < 4) ? TSTR : 0;
      2: return (i == 0) ? 3 : (i == 1) ? TAW : (i < 4) ? TOUT : 0;
      3: return (i == 0) ? 1 : (i < 4) ? TSTR : (i == 4) ? TVN : 0;
      4, 5: return (i == 0) ? 1 : (i == 1) ? 29 : 0;
      6: return (i == 0) ? 8 : 0;
      default: return (i < 2) ? TAW : (i < 5) ? TSTAT : (i == 5) ? TSTA : 0;
    endcase
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0, 1, 2: return "R2";
      3: return "R4";
      7: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic add_instr(input int op, input int rep);
    logic [NS*FW-1:0] e;
    logic [NS*FW-1:0] m;
    logic [31:0] v;
    int w;
    e = '0;
    m = '0;
    for (int b = 2; b >= 0; b--) bq.push_back(op[b]);
    total_bits += 3;
    for (int i = 0; i < NS; i++) begin
      w = tw(op, i);
      if (w > 0) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        if (rep % 4 == 1)      v = 32'hFFFF_FFFF;
        else if (rep % 4 == 2) v = 32'h0;
        else                   v = seed >> 3;
        v = v & ((32'h1 << w) - 32'h1);
        if (op <= 2 && i == 0) v = 32'(rep % 8);
        e[i*FW +: FW] = FW'(v);
        m[i*FW +: FW] = FW'((32'h1 << w) - 32'h1);
        for (int b = w - 1; b >= 0; b--) bq.push_back(v[b]);
        total_bits += w;
      end
    end
    eop.push_back(3'(op));
    efl.push_back(e);
    emsk.push_back(m);
    eerr.push_back((op <= 2) && ((rep % 8) > 5));
    n_instr++;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [NS*FW-1:0] act, input logic [NS*FW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    int cyc;
    int nb;
    bit held;
    logic [2:0] h_op;
    logic h_err;
    logic [NS*FW-1:0] h_fld;
    held = 1'b0;
    h_op = '0;
    h_err = 1'b0;
    h_fld = '0;

    for (int rep = 0; rep < 16; rep++)
      for (int op = 0; op < 8; op++) add_instr(op, rep);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", {173'b0, out_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", {173'b0, in_ready}, 1);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", {173'b0, out_valid}, '0);

    cyc = 0;
    while ((bq.size() > 0 || eop.size() > 0) && cyc < 20000) begin
      // drive this cycle's inputs
      out_ready = (cyc % 5 != 2) && (cyc % 11 != 4);
      nb = ((cyc / 3) % IN_W) + 1;
      if (nb > bq.size()) nb = bq.size();
      in_valid = (nb > 0) && (cyc % 7 != 3);
      in_nbits = NBW'(nb);
      for (int k = 0; k < IN_W; k++)
        in_data[IN_W-1-k] = (k < nb) ? bq[k] : 1'b1;
      #(CLK_P/4);

      if (held) begin
        chk(out_valid && out_op == h_op && out_fld == h_fld && out_err == h_err,
            "R8", "record held while stalled", out_fld, h_fld);
        held = 1'b0;
      end
      if (out_valid && !out_ready) begin
        chk(!in_ready, "R8", "in_ready low while stalled", {173'b0, in_ready}, '0);
        held = 1'b1;
        h_op = out_op; h_fld = out_fld; h_err = out_err;
      end
      if (out_valid && out_ready) begin
        n_out++;
        if (eop.size() == 0) begin
          chk(1'b0, "R1", "unexpected extra record", {171'b0, out_op}, '0);
        end else begin
          chk(out_op == eop[0] && (out_fld & emsk[0]) == efl[0], req_of(int'(eop[0])),
              $sformatf("record %0d op %0d fields", n_out, eop[0]), out_fld, efl[0]);
          chk(out_err == eerr[0], "R6", $sformatf("error flag record %0d", n_out),
              {173'b0, out_err}, {173'b0, eerr[0]});
          chk((out_fld & ~emsk[0]) == '0, "R10", $sformatf("unused bits record %0d", n_out),
              out_fld & ~emsk[0], '0);
          void'(eop.pop_front());
          void'(efl.pop_front());
          void'(emsk.pop_front());
          void'(eerr.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        for (int k = 0; k < nb; k++) void'(bq.pop_front());
        taken_bits += nb;
      end
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    out_ready = 1'b1;

    if (cyc >= 20000) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired: actual=%0d records expected=%0d", n_out, n_instr);
    end

    repeat (4) @(negedge clk);
    #(CLK_P/4);
    chk(out_valid == 1'b0, "R1", "no record after stream end", {173'b0, out_valid}, '0);
    chk(n_out == n_instr, "R1", "record count", (NS*FW)'(n_out), (NS*FW)'(n_instr));
    chk(taken_bits == total_bits, "R7", "bits consumed across beats",
        (NS*FW)'(taken_bits), (NS*FW)'(total_bits));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule